// File: doc/BRIEF.md
# Safe Clock Switch Controller

This controller chooses which oscillator drives the system clock: the internal fast RC divided by 8 (the base clock), the internal fast RC at full rate, the internal slow RC, or an external oscillator. It only produces mux select signals. The oscillators and the glitch-free clock mux cells sit outside it. A switch request names a target source. The controller holds the current selection until the oscillator behind the target reports ready. It then drops every select for one cycle before it enables the new one, so the old clock is always released before the new clock is applied.

Two events override software and force the base clock. The first is a failure of the external oscillator, which also raises a sticky interrupt. The second is a wakeup from halt. After a wakeup the controller waits a programmable number of cycles, then runs a normal ready-gated switch back to the source that was in use before halt. Selecting the slow RC needs an option enable. A newer request replaces a pending one.

Top module: `clksw_top`

## Requirements
- R1: After reset selSrc is 0 (fast RC divided by 8), clkSel is 4'b0001, busy is 0 and failIrq is 0.
- R2: Source codes are 0 = fast RC/8, 1 = fast RC, 2 = slow RC, 3 = external. Codes 0 and 1 use fastRdy, code 2 uses slowRdy and code 3 uses extRdy. An accepted request for a source other than the current one raises busy in the next cycle. selSrc and clkSel do not change while the target's ready input stays low.
- R3: In the cycle after the target is seen ready, clkSel is all zero. In the cycle after that, selSrc holds the target, clkSel is its one-hot value and busy is 0.
- R4: A request accepted while a switch is pending replaces the pending target. A request for the currently selected source ends the pending switch, and busy is 0 in the next cycle.
- R5: A request for code 2 is ignored while slowEnOpt is 0.
- R6: When extFail is high while the external source is selected or is the pending target, the next cycle shows selSrc 0, clkSel 4'b0001, busy 0 and failIrq 1.
- R7: failIrq sets on any cycle with extFail high and stays set until a cycle with failClr high and extFail low. While failIrq is set, or extFail is high, requests for code 3 are ignored.
- R8: A wakeUp pulse forces selSrc to 0 in the next cycle. After the stabilization count of cycles the controller switches back, gated by ready as in R2 and R3, to the source selected (or pending) before the pulse. If that source is 0, or is 3 while failIrq is set, no switch follows.
- R9: The stabilization count is stabCfg, or STAB_DEFAULT (16) when stabCfg is 0.
- R10: When clkSel is not in a release cycle, it has exactly one bit set: bit i set means source code i is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Switch request strobe |
| reqSrc | input | 2 | Requested source code |
| slowEnOpt | input | 1 | Option enable for the slow RC as system clock |
| fastRdy | input | 1 | Fast RC ready |
| slowRdy | input | 1 | Slow RC ready |
| extRdy | input | 1 | External oscillator ready |
| extFail | input | 1 | External clock failure detected |
| failClr | input | 1 | Clears the failure interrupt |
| wakeUp | input | 1 | Wakeup-from-halt pulse |
| stabCfg | input | STAB_W | Stabilization cycle count, 0 selects the default |
| selSrc | output | 2 | Selected source code |
| clkSel | output | 4 | One-hot mux enables, all zero while releasing |
| busy | output | 1 | Switch or stabilization in progress |
| failIrq | output | 1 | Sticky clock-failure interrupt |

## Verification
A wrong internal target or sequencer state shows at the ports within one or two cycles of the target's ready input rising. The symptoms are a missing all-zero release cycle on clkSel, the wrong code landing on selSrc, or busy staying high. An error in the stabilization counter shows only at the end of the wait after a wakeup, as a return that comes early or late by the counting error. A behavioural model in the bench compares every output on every cycle, so each of these shows up on the first cycle it differs.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int NUM_SRC = 4;

  typedef enum logic [1:0] {
    SRC_BASE = 2'd0,
    SRC_FAST = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STAB = 2'd1,
    ST_WAIT = 2'd2,
    ST_GAP  = 2'd3
  } st_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic forceBase;
    logic loadTgt;
    src_e tgtVal;
    logic commit;
    logic loadCnt;
    logic decCnt;
    logic gapNow;
  } strobe_t;
endpackage

// File: rtl/clksw_dp.sv
module clksw_dp
  import clksw_pkg::*;
#(
  parameter int STAB_W       = 8,
  parameter int STAB_DEFAULT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              fastRdy,
  input  logic              slowRdy,
  input  logic              extRdy,
  input  logic [STAB_W-1:0] stabCfg,
  output src_e              selSrc,
  output src_e              tgtSrc,
  output logic              cntOne,
  output logic              tgtRdy,
  output logic [NUM_SRC-1:0] clkSel
);
  localparam logic [STAB_W-1:0] DEF_CNT = STAB_W'(STAB_DEFAULT);

  logic [STAB_W-1:0] stabCnt;
  logic [STAB_W-1:0] stabLoad;

  assign stabLoad = (stabCfg == '0) ? DEF_CNT : stabCfg;
  assign cntOne   = (stabCnt == STAB_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selSrc  <= SRC_BASE;
      tgtSrc  <= SRC_BASE;
      stabCnt <= '0;
    end else begin
      if (stb.forceBase)   selSrc <= SRC_BASE;
      else if (stb.commit) selSrc <= tgtSrc;
      if (stb.loadTgt) tgtSrc <= stb.tgtVal;
      if (stb.loadCnt)     stabCnt <= stabLoad;
      else if (stb.decCnt) stabCnt <= stabCnt - STAB_W'(1);
    end
  end

  always_comb begin
    unique case (tgtSrc)
      SRC_BASE, SRC_FAST: tgtRdy = fastRdy;
      SRC_SLOW:           tgtRdy = slowRdy;
      default:            tgtRdy = extRdy;
    endcase
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    assign clkSel[i] = !stb.gapNow && (selSrc == src_e'(i));
  end

  // R10: outside a release cycle exactly one enable is active
  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.gapNow |-> $countones(clkSel) == 1);

  // R3: selection only moves through a commit or a forced fallback
  p_sel_moves_r3: assert property (@(posedge clk) disable iff (!rstN)
    (selSrc != $past(selSrc)) |-> ($past(stb.commit) || $past(stb.forceBase)));
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSrc,
  input  logic       slowEnOpt,
  input  logic       extFail,
  input  logic       failClr,
  input  logic       wakeUp,
  input  src_e       selSrc,
  input  src_e       tgtSrc,
  input  logic       cntOne,
  input  logic       tgtRdy,
  output strobe_t    stb,
  output logic       busy,
  output logic       failIrq
);
  st_e  state, stateNext;
  src_e reqCode, restoreSrc;
  logic failHit, reqOk;

  assign reqCode    = src_e'(reqSrc);
  assign restoreSrc = (state != ST_IDLE) ? tgtSrc : selSrc;
  assign failHit    = extFail && (selSrc == SRC_EXT ||
                                  (state != ST_IDLE && tgtSrc == SRC_EXT));
  assign reqOk      = reqValid
                   && !(reqCode == SRC_SLOW && !slowEnOpt)
                   && !(reqCode == SRC_EXT && (failIrq || extFail));

  always_comb begin
    stb        = '0;
    stb.tgtVal = SRC_BASE;
    stb.gapNow = (state == ST_GAP);
    stateNext  = state;
    if (failHit) begin
      stb.forceBase = 1'b1;
      stateNext     = ST_IDLE;
    end else if (wakeUp) begin
      stb.forceBase = 1'b1;
      if (restoreSrc == SRC_BASE || (restoreSrc == SRC_EXT && failIrq)) begin
        stateNext = ST_IDLE;
      end else begin
        stb.loadTgt = 1'b1;
        stb.tgtVal  = restoreSrc;
        stb.loadCnt = 1'b1;
        stateNext   = ST_STAB;
      end
    end else if (reqOk) begin
      if (reqCode == selSrc) begin
        stateNext = ST_IDLE;
      end else begin
        stb.loadTgt = 1'b1;
        stb.tgtVal  = reqCode;
        stateNext   = ST_WAIT;
      end
    end else begin
      unique case (state)
        ST_STAB: begin
          if (cntOne) stateNext = ST_WAIT;
          else        stb.decCnt = 1'b1;
        end
        ST_WAIT: if (tgtRdy) stateNext = ST_GAP;
        ST_GAP: begin
          stb.commit = 1'b1;
          stateNext  = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      failIrq <= 1'b0;
    end else begin
      state <= stateNext;
      if (extFail)      failIrq <= 1'b1;
      else if (failClr) failIrq <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);

  // R2: the release cycle is only entered once the target was ready
  p_gap_needs_ready_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> ($past(tgtRdy) && $past(state) == ST_WAIT));

  // R3: the release lasts a single cycle
  p_gap_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |=> (state != ST_GAP));

  // R5: slow source refused without its option
  p_slow_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && reqSrc == 2'd2 && !slowEnOpt && !wakeUp && !extFail)
      |=> (state == ST_IDLE));

  // R6: external failure falls back to the base clock and flags
  p_fail_fallback_r6: assert property (@(posedge clk) disable iff (!rstN)
    (extFail && selSrc == SRC_EXT) |=> (selSrc == SRC_BASE && failIrq && !busy));

  // R7: interrupt is sticky until cleared
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (failIrq && !failClr) |=> failIrq);

  // R7: external requests refused while flagged
  p_ext_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && failIrq && reqValid && reqSrc == 2'd3 && !wakeUp && !extFail)
      |=> (state == ST_IDLE));

  // R8: wakeup lands on the base clock at once
  p_wake_base_r8: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |=> (selSrc == SRC_BASE));
endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter int STAB_W       = 8,
  parameter int STAB_DEFAULT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqSrc,
  input  logic              slowEnOpt,
  input  logic              fastRdy,
  input  logic              slowRdy,
  input  logic              extRdy,
  input  logic              extFail,
  input  logic              failClr,
  input  logic              wakeUp,
  input  logic [STAB_W-1:0] stabCfg,
  output logic [1:0]        selSrc,
  output logic [3:0]        clkSel,
  output logic              busy,
  output logic              failIrq
);
  strobe_t stb;
  src_e    selE, tgtE;
  logic    cntOne, tgtRdy;

  clksw_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .reqSrc, .slowEnOpt, .extFail, .failClr, .wakeUp,
    .selSrc(selE), .tgtSrc(tgtE), .cntOne, .tgtRdy,
    .stb, .busy, .failIrq
  );

  clksw_dp #(.STAB_W(STAB_W), .STAB_DEFAULT(STAB_DEFAULT)) u_dp (
    .clk, .rstN, .stb, .fastRdy, .slowRdy, .extRdy, .stabCfg,
    .selSrc(selE), .tgtSrc(tgtE), .cntOne, .tgtRdy, .clkSel
  );

  assign selSrc = selE;
endmodule

// File: tb/clksw_top_tb_top.sv
`timescale 1ns/1ps
module clksw_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 0, slowEnOpt = 0, fastRdy = 0, slowRdy = 0, extRdy = 0;
  logic       extFail = 0, failClr = 0, wakeUp = 0;
  logic [1:0] reqSrc = 0;
  logic [7:0] stabCfg = 0;
  logic [1:0] selSrc;
  logic [3:0] clkSel;
  logic       busy, failIrq;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  clksw_top dut_i (
    .clk, .rstN, .reqValid, .reqSrc, .slowEnOpt, .fastRdy, .slowRdy, .extRdy,
    .extFail, .failClr, .wakeUp, .stabCfg, .selSrc, .clkSel, .busy, .failIrq
  );

  // behavioural reference: 0 idle, 1 settling, 2 waiting ready, 3 release
  int mSel = 0, mTgt = 0, mSt = 0, mCnt = 0, mFail = 0;
  int tRest, tRdy;
  bit tHit, tOk;

  always @(posedge clk) begin
    if (!rstN) begin
      mSel = 0; mTgt = 0; mSt = 0; mCnt = 0; mFail = 0;
    end else begin
      tHit  = extFail && (mSel == 3 || (mSt != 0 && mTgt == 3));
      tRest = (mSt != 0) ? mTgt : mSel;
      tOk   = reqValid && !(reqSrc == 2 && !slowEnOpt) && !(reqSrc == 3 && (mFail != 0 || extFail));
      tRdy  = (mTgt == 3) ? int'(extRdy) : (mTgt == 2) ? int'(slowRdy) : int'(fastRdy);
      if (tHit) begin
        mSel = 0; mSt = 0;
      end else if (wakeUp) begin
        mSel = 0;
        if (tRest == 0 || (tRest == 3 && mFail != 0)) mSt = 0;
        else begin
          mTgt = tRest; mSt = 1;
          mCnt = (stabCfg == 0) ? 16 : int'(stabCfg);
        end
      end else if (tOk) begin
        if (int'(reqSrc) == mSel) mSt = 0;
        else begin mTgt = int'(reqSrc); mSt = 2; end
      end else begin
        case (mSt)
          1: if (mCnt == 1) mSt = 2; else mCnt = mCnt - 1;
          2: if (tRdy != 0) mSt = 3;
          3: begin mSel = mTgt; mSt = 0; end
          default: ;
        endcase
      end
      if (extFail) mFail = 1; else if (failClr) mFail = 0;
    end
  end

  // per-cycle comparison against the reference (covers R1..R10)
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      int expClk;
      expClk = (mSt == 3) ? 0 : (1 << mSel);
      checks++;
      if (int'(selSrc) != mSel || int'(clkSel) != expClk ||
          int'(busy) != int'(mSt != 0) || int'(failIrq) != mFail) begin
        fails++;
        $display("FAIL model R2/R3/R10 cycle %0d: sel=%0d clk=%b busy=%0d irq=%0d expected sel=%0d clk=%b busy=%0d irq=%0d",
                 cyc, selSrc, clkSel, busy, failIrq, mSel, expClk[3:0], int'(mSt != 0), mFail);
      end
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired, got running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(int src);
    reqSrc = 2'(src); reqValid = 1;
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1;
    @(negedge clk);
    s = 0;
  endtask

  initial begin
    waitN(3);
    rstN = 1;
    waitN(1);
    chk("R1 selSrc", selSrc, 0);
    chk("R1 clkSel", clkSel, 1);
    chk("R1 busy", busy, 0);
    chk("R1 failIrq", failIrq, 0);

    fastRdy = 1;
    request(3);                          // external not ready
    waitN(4);
    chk("R2 held busy", busy, 1);
    chk("R2 held sel", selSrc, 0);
    request(1);                          // replaces pending target
    chk("R4 replace still waiting", busy, 1);
    waitN(1);
    chk("R3 release cycle", clkSel, 0);
    waitN(1);
    chk("R4 new target", selSrc, 1);
    chk("R3 enable", clkSel, 4'b0010);
    chk("R3 busy drop", busy, 0);

    request(2);                          // no option
    chk("R5 ignored", busy, 0);
    waitN(2);
    chk("R5 sel kept", selSrc, 1);
    slowEnOpt = 1; slowRdy = 1;
    request(2);
    waitN(2);
    chk("R5 slow allowed", selSrc, 2);

    request(3);                          // pending, ext not ready
    waitN(2);
    request(2);                          // same as current: cancel
    chk("R4 cancel", busy, 0);
    chk("R4 cancel sel", selSrc, 2);

    extRdy = 1;
    request(3);
    waitN(2);
    chk("R2 ext selected", selSrc, 3);
    chk("R10 ext enable", clkSel, 4'b1000);
    pulse(extFail);
    chk("R6 fallback sel", selSrc, 0);
    chk("R6 fallback clk", clkSel, 1);
    chk("R6 irq", failIrq, 1);
    waitN(3);
    chk("R7 sticky", failIrq, 1);
    request(3);
    chk("R7 ext refused", busy, 0);
    waitN(3);
    chk("R7 ext refused sel", selSrc, 0);
    pulse(failClr);
    chk("R7 cleared", failIrq, 0);

    request(3);
    waitN(2);
    chk("R8 pre-halt ext", selSrc, 3);
    stabCfg = 0;
    pulse(wakeUp);
    chk("R8 base at wake", selSrc, 0);
    chk("R8 busy at wake", busy, 1);
    waitN(15);
    chk("R9 default still settling", selSrc, 0);
    chk("R9 default clk", clkSel, 1);
    waitN(2);
    chk("R8 release", clkSel, 0);
    waitN(1);
    chk("R9 restored after 16", selSrc, 3);

    stabCfg = 8'd5;
    pulse(wakeUp);
    waitN(6);
    chk("R9 short release", clkSel, 0);
    waitN(1);
    chk("R9 short restored", selSrc, 3);

    request(0);
    waitN(2);
    chk("R8 base selected", selSrc, 0);
    pulse(wakeUp);
    chk("R8 no restore from base", busy, 0);

    request(1);
    waitN(2);
    chk("R8 fast selected", selSrc, 1);
    pulse(wakeUp);
    waitN(1);
    pulse(extFail);
    chk("R6 fast unaffected irq", failIrq, 1);
    waitN(8);
    chk("R8 restore fast", selSrc, 1);

    waitN(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule